// File: doc/BRIEF.md
# NAK Counter Reload Sequencer

This block decides when a host controller may refill the per-endpoint NAK counters while it walks its circular list of asynchronous queue heads. Each queue-head fetch is reported by a single-cycle strobe. The strobe carries two things: a flag marking the queue head that is the head of the list, and the 4-bit reload value of that queue head. A separate one-cycle event marks each start of microframe.

The sequencer has three phases. In the first it waits for the head of the list. In the second it allows reloads, which lasts one full lap of the list. In the third it waits for the next start event before it looks for the head again. As a result, counters are refilled during at most one lap of the list per start event.

For each fetch the block returns a reload-enable bit in the same cycle. The caller uses that bit to copy the reload value into the queue head's NAK counter. The counters, memory traffic and transaction execution belong to the surrounding controller.

Top module: `nak_reload_seq`

## Requirements
- R1: A synchronous active-high reset puts `state_o` into the head-search phase, encoded 2'b00. Reset also forces `reload_en_o` low.
- R2: In the head-search phase, a fetch strobe with the head flag set moves `state_o` to the reload phase (2'b01) at the next clock edge.
- R3: In the reload phase, a fetch strobe with the head flag set moves `state_o` to the start-wait phase (2'b10) at the next clock edge.
- R4: In the reload phase, every fetch strobe whose reload value is non-zero drives `reload_en_o` high in the same cycle. This includes the head-flagged fetch that ends the phase.
- R5: In the start-wait phase, `reload_en_o` stays low. A start-of-microframe event returns `state_o` to 2'b00 at the next edge.
- R6: A fetch whose reload value is zero never drives `reload_en_o` high, in any phase.
- R7: In the head-search phase, a fetch without the head flag gives no reload and leaves `state_o` unchanged.
- R8: A start event in the head-search or reload phase is ignored. A fetch without the head flag in the reload phase leaves `state_o` unchanged. A head-flagged fetch in the start-wait phase also leaves `state_o` unchanged.
- R9: `reload_en_o` is low in any cycle without a fetch strobe.
- R10: When a start event and a fetch come in the same cycle of the start-wait phase, the machine returns to 2'b00 and `reload_en_o` stays low for that fetch.
- R11: `reload_en_o` is decided by the phase held before the clock edge. Its value is not affected by the transition that the same fetch causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-microframe event, one cycle |
| fetch_vld_i | input | 1 | Queue-head fetch strobe |
| fetch_head_i | input | 1 | Head-of-list flag of the fetched queue head |
| fetch_rl_i | input | RL_W | Reload value of the fetched queue head |
| state_o | output | 2 | Current phase: 00 head-search, 01 reload, 10 start-wait |
| reload_en_o | output | 1 | Reload permitted for the current fetch |

## Verification
Directed sequences drive the machine through full laps of the list. The first head fetch must not reload, while the second head fetch must reload. Non-head fetches with zero and non-zero reload values tell the reload phase apart from the two quiet phases. Start events are placed in each phase, and one lands in the same cycle as a fetch, so the tests show that the event is honoured only while waiting. Random traffic with rare head flags and start events then checks many laps against a reference model in the bench, covering both long and short laps.

// File: rtl/nrl_pkg.sv
package nrl_pkg;

    localparam int NRL_STATE_W = 2;

    typedef enum logic [NRL_STATE_W-1:0] {
        NRL_SEEK_HEAD = 2'b00,
        NRL_RELOAD    = 2'b01,
        NRL_WAIT_SOF  = 2'b10
    } nrl_state_e;

    typedef struct packed {
        logic vld;
        logic head;
    } nrl_fetch_t;

    function automatic nrl_state_e nrl_next(nrl_state_e cur, nrl_fetch_t f, logic sof);
        nrl_state_e nxt;
        nxt = cur;
        unique case (cur)
            NRL_SEEK_HEAD: if (f.vld && f.head) nxt = NRL_RELOAD;
            NRL_RELOAD:    if (f.vld && f.head) nxt = NRL_WAIT_SOF;
            NRL_WAIT_SOF:  if (sof)             nxt = NRL_SEEK_HEAD;
            default:                            nxt = NRL_SEEK_HEAD;
        endcase
        return nxt;
    endfunction

    function automatic logic nrl_phase_allows(nrl_state_e cur);
        return cur == NRL_RELOAD;
    endfunction

endpackage

// File: rtl/nrl_state.sv
module nrl_state
    import nrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  nrl_fetch_t fetch,
    output nrl_state_e state
);
    nrl_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= NRL_SEEK_HEAD;
        else     state_q <= nrl_next(state_q, fetch, sof);
    end

    assign state = state_q;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> state_q == NRL_SEEK_HEAD);
    p_head_to_reload_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == NRL_SEEK_HEAD && fetch.vld && fetch.head) |=> state_q == NRL_RELOAD);
    p_reload_to_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == NRL_RELOAD && fetch.vld && fetch.head) |=> state_q == NRL_WAIT_SOF);
    p_sof_return_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == NRL_WAIT_SOF && sof) |=> state_q == NRL_SEEK_HEAD);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(fetch.vld && fetch.head) && !sof) |=> $stable(state_q));
    p_legal_r1: assert property (@(posedge clk) disable iff (rst)
        state_q != 2'b11);
endmodule

// File: rtl/nrl_gate.sv
module nrl_gate
    import nrl_pkg::*;
#(
    parameter int RL_W = 4
) (
    input  nrl_state_e      state,
    input  nrl_fetch_t      fetch,
    input  logic [RL_W-1:0] rl,
    output logic            en
);
    logic rl_nonzero;

    always_comb begin
        rl_nonzero = |rl;
        en = fetch.vld && rl_nonzero && nrl_phase_allows(state);
    end
endmodule

// File: rtl/nak_reload_seq.sv
module nak_reload_seq
    import nrl_pkg::*;
#(
    parameter int RL_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sof_i,
    input  logic            fetch_vld_i,
    input  logic            fetch_head_i,
    input  logic [RL_W-1:0] fetch_rl_i,
    output logic [1:0]      state_o,
    output logic            reload_en_o
);
    nrl_fetch_t fetch;
    nrl_state_e state;
    logic       gate_en;

    assign fetch = '{vld: fetch_vld_i, head: fetch_head_i};

    nrl_state u_state (
        .clk   (clk),
        .rst   (rst),
        .sof   (sof_i),
        .fetch (fetch),
        .state (state)
    );

    nrl_gate #(.RL_W(RL_W)) u_gate (
        .state (state),
        .fetch (fetch),
        .rl    (fetch_rl_i),
        .en    (gate_en)
    );

    assign state_o     = state;
    assign reload_en_o = gate_en && !rst;

    p_reload_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (state == NRL_RELOAD && fetch_vld_i && fetch_rl_i != '0) |-> reload_en_o);
    p_quiet_wait_r5: assert property (@(posedge clk) disable iff (rst)
        state == NRL_WAIT_SOF |-> !reload_en_o);
    p_zero_rl_r6: assert property (@(posedge clk) disable iff (rst)
        fetch_rl_i == '0 |-> !reload_en_o);
    p_quiet_seek_r7: assert property (@(posedge clk) disable iff (rst)
        state == NRL_SEEK_HEAD |-> !reload_en_o);
    p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld_i |-> !reload_en_o);
endmodule

// File: tb/test_nak_reload_seq.sv
module test_nak_reload_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RL_W       = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sof_i = 1'b0;
    logic            fetch_vld_i = 1'b0;
    logic            fetch_head_i = 1'b0;
    logic [RL_W-1:0] fetch_rl_i = '0;
    logic [1:0]      state_o;
    logic            reload_en_o;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_state = 2'b00;
    string      state_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    nak_reload_seq #(.RL_W(RL_W)) i_nak_reload_seq (
        .clk, .rst, .sof_i, .fetch_vld_i, .fetch_head_i, .fetch_rl_i,
        .state_o, .reload_en_o
    );

    function automatic logic [1:0] model_next(logic [1:0] s, logic sof, logic vld, logic head);
        case (s)
            2'b00:   return (vld && head) ? 2'b01 : 2'b00;
            2'b01:   return (vld && head) ? 2'b10 : 2'b01;
            2'b10:   return sof ? 2'b00 : 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic model_en(logic [1:0] s, logic vld, logic [RL_W-1:0] rl);
        return vld && (rl != 0) && (s == 2'b01);
    endfunction

    function automatic string en_tag(logic [1:0] s, logic sof, logic vld, logic [RL_W-1:0] rl);
        if (!vld)                 return "R9";
        if (rl == 0)              return "R6";
        if (s == 2'b10 && sof)    return "R10";
        if (s == 2'b10)           return "R5";
        if (s == 2'b00)           return "R7";
        return "R4 R11";
    endfunction

    function automatic string st_tag(logic [1:0] s, logic sof, logic vld, logic head);
        if (s == 2'b00 && vld && head) return "R2";
        if (s == 2'b01 && vld && head) return "R3";
        if (s == 2'b10 && sof && vld)  return "R10";
        if (s == 2'b10 && sof)         return "R5";
        if (s == 2'b00 && vld)         return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(logic sof, logic vld, logic head, logic [RL_W-1:0] rl);
        @(negedge clk);
        check(state_tag, state_o, exp_state);
        sof_i = sof; fetch_vld_i = vld; fetch_head_i = head; fetch_rl_i = rl;
        #1;
        check(en_tag(exp_state, sof, vld, rl), {1'b0, reload_en_o},
              {1'b0, model_en(exp_state, vld, rl)});
        state_tag = st_tag(exp_state, sof, vld, head);
        exp_state = model_next(exp_state, sof, vld, head);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        fetch_vld_i = 1'b1; fetch_rl_i = 4'd7; #1;
        check("R1", state_o, 2'b00);
        check("R1", {1'b0, reload_en_o}, 2'b00);
        @(negedge clk);
        rst = 1'b0; fetch_vld_i = 1'b0; fetch_rl_i = '0;

        // R7 / R8: non-head fetches and a stray start event while seeking
        step(0, 1, 0, 4'd5);
        step(1, 0, 0, 4'd0);
        // R2: head found, no reload for it (R11)
        step(0, 1, 1, 4'd9);
        // R4 / R6 / R8 inside the reload lap
        step(0, 1, 0, 4'd3);
        step(0, 1, 0, 4'd0);
        step(1, 0, 0, 4'd2);
        step(0, 1, 0, 4'd15);
        // R3 with R11: head again reloads, then leaves the phase
        step(0, 1, 1, 4'd1);
        // R5 / R8: quiet while waiting, head ignored
        step(0, 1, 1, 4'd4);
        step(0, 1, 0, 4'd6);
        // R10: start and fetch together
        step(1, 1, 0, 4'd8);
        step(0, 1, 1, 4'd2);
        step(0, 1, 1, 4'd2);
        step(0, 1, 0, 4'd0);
        step(0, 1, 1, 4'd2);
        step(1, 0, 0, 4'd0);
        // Random traffic with rare head flags and start events
        for (int i = 0; i < 3000; i++) begin
            logic s, v, h;
            logic [RL_W-1:0] r;
            s = ($urandom % 12) == 0;
            v = ($urandom % 3) != 0;
            h = ($urandom % 7) == 0;
            r = (($urandom % 4) == 0) ? '0 : RL_W'($urandom);
            step(s, v, h, r);
        end
        step(0, 0, 0, 4'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule